// File: doc/BRIEF.md
# Weighted Load-Tracking Frequency Requester

This block estimates how busy a processor is and tells a clock controller when a different operating frequency is called for. Each time a sample strobe arrives it adds up a 3-bit weight for every activity input that is currently high. Twelve of those inputs come from hardware and four are bits held in a register that software writes. The sum is limited to 63, then smoothed with an exponential moving average whose length is a power of two that software picks.

The integer part of the smoothed load is compared against three 6-bit thresholds. A low load that persists for a programmed number of consecutive samples asks for a lower frequency. A high load that persists for a separately programmed number of samples asks for a higher one. A load above the panic threshold asks for an emergency raise at once. The request is presented as a 2-bit code with a maskable interrupt and stays until the consumer acknowledges it. A small write-only register port sets the weights, thresholds, streak lengths, averaging shift, mask and enable.

Top module: `load_tracker`

## Requirements
- R1: After reset the request code is 00 and the interrupt is low; every weight, threshold, count and software bit is zero and the tracker is disabled.
- R2: The load of a sample is the sum of the weights of the active inputs, limited to 63. Input i (0..11 from `act_in`, 12..15 from the software bits) has a 3-bit weight at bits [3(i mod 8)+2 : 3(i mod 8)] of register 3 (i<8) or register 4 (i>=8). A weight of 0 removes the input.
- R3: Register 5 holds the four software activity bits in bits [3:0], driving inputs 12..15; bits above 3 of that write are ignored.
- R4: On each strobe while enabled the average becomes avg + (load - avg) >> k, with 8 fraction bits kept, where k is register 0 bits [4:2]; with k = 0 the average equals the load.
- R5: Register 1 holds the down threshold in [5:0], up in [13:8], panic in [21:16]; register 2 holds the up count in [7:0] and down count in [15:8]. A decrease request (code 10) is raised on the sample that makes the down count of consecutive samples with average below the down threshold.
- R6: An increase request (code 01) is raised on the sample that makes the up count of consecutive samples with average above the up threshold; a count of 0 acts as 1.
- R7: An emergency request (code 11) is raised on the first sample whose average exceeds the panic threshold, taking priority over an increase; it clears both streaks.
- R8: A sample on which a condition does not hold restarts that condition's streak, and a streak that reaches its count restarts whether or not its request was taken.
- R9: A nonzero code holds until a one-cycle pulse on `req_ack`, which clears it on the next edge; no new code is taken while a code is pending or in the acknowledge cycle.
- R10: `req_irq` is high when the code is nonzero and the mask bit (register 0 bit 1) is clear; it is low whenever the mask bit is set.
- R11: While the enable bit (register 0 bit 0) is clear the code is 00, both streaks are cleared and the average is held; after re-enabling, streaks start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle sample strobe from a clock divider |
| act_in | input | 12 | Hardware activity inputs 0..11 |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| req_ack | input | 1 | Acknowledge pulse that clears the request |
| req_code | output | 2 | 00 none, 01 increase, 10 decrease, 11 emergency |
| req_irq | output | 1 | Request interrupt after the mask |

## Verification
The hardest situation to reach is a streak that completes while an earlier request is still pending, because the code does not change and only a later sample reveals that the streak was restarted. The stimulus lets an increase stand unacknowledged through two low-load samples, acknowledges, and then shows that one more low sample still yields no decrease while the following one does. Averaging is exercised from a zero average with a shift of one, so the crossing appears only on the second sample of a constant load.

// File: rtl/load_tracker.sv
module load_tracker #(
  parameter int N_HW = 12,
  parameter int N_SW = 4,
  parameter int WW   = 3,
  parameter int TW   = 6,
  parameter int CW   = 8,
  parameter int KW   = 3,
  parameter int FRAC = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_stb,
  input  logic [N_HW-1:0] act_in,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            req_ack,
  output logic [1:0]      req_code,
  output logic            req_irq
);
  localparam int NIN     = N_HW + N_SW;
  localparam int PER_REG = 8;
  localparam int WT_BASE = 3;
  localparam int SW_ADDR = WT_BASE + (NIN + PER_REG - 1) / PER_REG;
  localparam int LSW     = $clog2(NIN * ((1 << WW) - 1) + 1);
  localparam int AVW     = TW + FRAC;
  localparam int TMAX    = (1 << TW) - 1;

  logic            en_q, mask_q;
  logic [KW-1:0]   k_q;
  logic [TW-1:0]   dn_thr, up_thr, pn_thr;
  logic [CW-1:0]   up_cnt, dn_cnt, up_run, dn_run;
  logic [N_SW-1:0] sw_q;
  logic [WW-1:0]   wt_q [NIN];
  logic [AVW-1:0]  avg_q;

  for (genvar i = 0; i < NIN; i++) begin : g_wt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) wt_q[i] <= '0;
      else if (cfg_we && cfg_addr == 3'(WT_BASE + i / PER_REG))
        wt_q[i] <= cfg_wdata[(i % PER_REG) * WW +: WW];
  end

  wire [NIN-1:0] act_all = {sw_q, act_in};
  logic [LSW-1:0] load_sum;
  always_comb begin
    load_sum = '0;
    for (int i = 0; i < NIN; i++)
      if (act_all[i]) load_sum = load_sum + LSW'(wt_q[i]);
  end

  wire [TW-1:0] load_sat = (load_sum > LSW'(TMAX)) ? TW'(TMAX) : load_sum[TW-1:0];

  wire signed [AVW+1:0] diff    = $signed({2'b00, load_sat, {FRAC{1'b0}}}) - $signed({2'b00, avg_q});
  wire signed [AVW+1:0] avg_sum = $signed({2'b00, avg_q}) + (diff >>> k_q);
  wire [AVW-1:0]        avg_nxt = avg_sum[AVW-1:0];
  wire [TW-1:0]         lvl     = avg_nxt[AVW-1:FRAC];

  wire c_pn = lvl > pn_thr;
  wire c_up = lvl > up_thr;
  wire c_dn = lvl < dn_thr;
  wire [CW-1:0] up_inc = up_run + 1'b1;
  wire [CW-1:0] dn_inc = dn_run + 1'b1;
  wire f_up = c_up && up_inc >= up_cnt;
  wire f_dn = c_dn && dn_inc >= dn_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mask_q <= 1'b0; k_q <= '0;
      dn_thr <= '0; up_thr <= '0; pn_thr <= '0;
      up_cnt <= '0; dn_cnt <= '0; sw_q <= '0;
      up_run <= '0; dn_run <= '0; avg_q <= '0;
      req_code <= 2'b00;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin
            en_q <= cfg_wdata[0]; mask_q <= cfg_wdata[1]; k_q <= cfg_wdata[2 +: KW];
          end
          3'd1: begin
            dn_thr <= cfg_wdata[0 +: TW]; up_thr <= cfg_wdata[8 +: TW]; pn_thr <= cfg_wdata[16 +: TW];
          end
          3'd2: begin
            up_cnt <= cfg_wdata[0 +: CW]; dn_cnt <= cfg_wdata[8 +: CW];
          end
          3'(SW_ADDR): sw_q <= cfg_wdata[N_SW-1:0];
          default: ;
        endcase
      end
      if (!en_q) begin
        up_run <= '0; dn_run <= '0; req_code <= 2'b00;
      end else begin
        if (req_ack) req_code <= 2'b00;
        if (sample_stb) begin
          avg_q  <= avg_nxt;
          up_run <= (!c_up || c_pn || f_up) ? '0 : up_inc;
          dn_run <= (!c_dn || c_pn || f_dn) ? '0 : dn_inc;
          if (!req_ack && req_code == 2'b00)
            req_code <= c_pn ? 2'b11 : f_up ? 2'b01 : f_dn ? 2'b10 : 2'b00;
        end
      end
    end
  end

  assign req_irq = (req_code != 2'b00) && !mask_q;
endmodule

module load_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stb,
  input logic       ack,
  input logic       en,
  input logic       msk,
  input logic [1:0] code,
  input logic       irq
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (code != 2'b00 && !ack && en) |=> code == $past(code));
  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> code == 2'b00);
  p_off_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> code == 2'b00);
  p_only_on_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b00 && !stb) |=> code == 2'b00);
  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msk |-> !irq);
endmodule

bind load_tracker load_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stb(sample_stb), .ack(req_ack),
  .en(en_q), .msk(mask_q), .code(req_code), .irq(req_irq)
);

// File: tb/tb_load_tracker.sv
`timescale 1ns/1ps
module tb_load_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_stb = 1'b0;
  logic [11:0] act_in = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_ack = 1'b0;
  logic [1:0]  req_code;
  logic        req_irq;

  int total = 0;
  int bad = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  load_tracker dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .act_in(act_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_ack(req_ack), .req_code(req_code), .req_irq(req_irq)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); req_ack = 1'b1;
    @(negedge clk); req_ack = 1'b0;
    check("R9 ack clears code", req_code, 0);
  endtask

  task automatic samp(input logic [11:0] a, input int exp, input string tag);
    @(negedge clk);
    act_in = a; sample_stb = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (sample_stb) begin
        @(negedge clk);
        check(tag_q.pop_front(), req_code, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset code", req_code, 0);
    check("R1 reset irq", req_irq, 0);
    rst_n = 1'b1;

    wr(3'd1, 32'd0 | (32'd25 << 8) | (32'd63 << 16));
    wr(3'd2, 32'd1 | (32'd1 << 8));
    wr(3'd3, 32'hFFFFFF);
    wr(3'd0, 32'd5);
    samp(12'h03F, 0, "R4 avg half way");
    samp(12'h03F, 1, "R4 avg crosses on second sample");
    ack();

    wr(3'd0, 32'd1);
    wr(3'd1, 32'd10 | (32'd40 << 8) | (32'd60 << 16));
    wr(3'd2, 32'd3 | (32'd2 << 8));
    wr(3'd4, 32'hFFF000);
    samp(12'h000, 0, "R5 first low sample");
    samp(12'h000, 2, "R5 decrease after two");
    check("R10 irq with code", req_irq, 1);
    ack();

    samp(12'h03F, 0, "R6 high 1");
    samp(12'h007, 0, "R8 mid breaks streak");
    samp(12'h03F, 0, "R8 high 1 again");
    samp(12'h03F, 0, "R6 high 2");
    samp(12'h03F, 1, "R6 increase after three");

    samp(12'h000, 1, "R9 pending held");
    samp(12'h000, 1, "R9 pending held while streak completes");
    ack();
    samp(12'h000, 0, "R8 streak restarted while blocked");
    samp(12'h000, 2, "R5 decrease after fresh streak");
    ack();

    wr(3'd5, 32'h0000000F);
    samp(12'h0FF, 3, "R7 panic on saturated load R2");
    ack();

    wr(3'd5, 32'h000000F0);
    samp(12'h0FF, 0, "R3 upper software bits ignored");
    samp(12'h007, 0, "R8 mid sample");

    wr(3'd3, 32'hFFFFF8);
    samp(12'h003, 0, "R2 zero weight low 1");
    samp(12'h003, 2, "R2 zero weight excludes input");
    ack();

    wr(3'd0, 32'd3);
    samp(12'h000, 0, "R10 masked low 1");
    samp(12'h000, 2, "R10 masked decrease");
    check("R10 irq masked", req_irq, 0);
    ack();

    wr(3'd0, 32'd0);
    samp(12'h000, 0, "R11 disabled 1");
    samp(12'h000, 0, "R11 disabled 2");
    samp(12'h000, 0, "R11 disabled 3");
    wr(3'd0, 32'd1);
    samp(12'h000, 0, "R11 streak cleared");
    samp(12'h000, 2, "R11 decrease after re-enable");
    ack();

    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule